// File: doc/BRIEF.md
# Fractional-increment PTP time counter

This block keeps a free-running hardware time value for a precision-time clock. Every cycle of the local clock counts as one tick. On each tick the block adds a programmable step to its time value. Software trims the clock frequency by changing that step, a little at a time, through a 32-bit register port. The port can read, write and program the step. Time is wider than one register word, so a read of the lowest-order time word freezes a copy of every time word. The other words are then read from that copy, and the words read belong to one instant. Writes are staged the same way: the staged words go into the counter together when the highest time word is written.

The `MODE` parameter picks one of two variants.

- **Fractional-increment variant.** A 45-bit accumulator counts in units of 2^-19 ns. It adds a 24-bit step every N ticks, where N comes from a period field. The nominal step is 16 ns, written 0x800000.
- **Fixed-step variant.** A 40-bit nanosecond count moves 8 ns per tick. A sign-and-magnitude correction word also feeds a 32-bit sub-nanosecond register, and that register's carry or borrow nudges the nanosecond count by one.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time reads 0 and the halt bit is clear. The step register reads 0x01800000 in the fractional-increment variant, which is period 1 with step 0x800000. It reads 0 in the fixed-step variant.
- R2: In the fractional-increment variant, with period 1, the accumulator grows by the step value (bits 23:0 of the step register) on every tick. The low word is accumulator bits 31:0 and the high word is accumulator bits 44:32.
- R3: The fractional-increment accumulator is 45 bits wide and wraps to 0 past 2^45-1. Bits 31:13 of its high word always read 0.
- R4: Bits 31:24 of the step register hold a period P, and P=0 acts as 1. The step is added on every P-th tick, counted from the last write of the step register or of the time.
- R5: A step value that differs from nominal by one fractional unit is added in full, so after k ticks the time is k times that value.
- R6: Bit 31 of the control register (address 4) halts counting while it is set. Staged time writes still commit while the counter is halted. Counting resumes on the tick after the bit is cleared.
- R7: A read of the lowest-order time word returns the live value and captures all time words. This word is the low word (address 1) in the fractional-increment variant and the sub-nanosecond word (address 0) in the fixed-step variant. Later reads of the other time words return the captured copy, which stays unchanged until the lowest-order word is read again.
- R8: Writes to the time words below the high word are only staged. Writing the high word (address 2) loads every time word at once. The step register is address 3.
- R9: In the fixed-step variant, with no correction, the 40-bit nanosecond count grows by exactly 8 per tick. A carry out of bit 31 of the low word moves into the high word.
- R10: In the fixed-step variant, when bit 31 of the step register is 0, bits 30:0 are added to the sub-nanosecond word each tick. Each carry out of that word adds one extra nanosecond.
- R11: In the fixed-step variant, when bit 31 of the step register is 1, bits 30:0 are subtracted from the sub-nanosecond word each tick. Each borrow takes one nanosecond off that tick's 8 ns.
- R12: In the fixed-step variant, bits 31:8 of the high word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; every rising edge is one tick |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_rd_en | input | 1 | Read strobe for the register port |
| reg_addr | input | 3 | Word address: 0 sub-ns, 1 low, 2 high, 3 step, 4 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |

## Verification
Read data comes back one cycle after the strobe. It holds the time as it stood just before the rising edge that took the read. A high-word write loads the counter on that same edge, and counting restarts on the next one. After each load the bench therefore counts the rising edges that pass before the lowest-word read, and it predicts the value as the loaded time plus that many steps, using the period and the carry or borrow pattern. Inputs are driven and outputs sampled on falling edges, so each read lands on a known edge. A halt or resume takes effect from the first edge after the control write.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;

    localparam int WORD_W   = 32;
    localparam int PER_W    = 8;
    localparam int HALT_BIT = 31;
    localparam int SIGN_BIT = 31;

    typedef enum logic {
        MODE_FRAC_INC   = 1'b0,
        MODE_FIXED_STEP = 1'b1
    } mode_e;

    typedef enum logic [2:0] {
        RA_SUB  = 3'd0,
        RA_LO   = 3'd1,
        RA_HI   = 3'd2,
        RA_STEP = 3'd3,
        RA_CTRL = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [WORD_W-1:0] sub;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
    } time_words_t;

    typedef struct packed {
        logic              load;
        logic [WORD_W-1:0] sub;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
    } load_req_t;

    function automatic logic [WORD_W-1:0] nominal_step(input int frac_w);
        logic [WORD_W-1:0] v;
        v = WORD_W'(16) << frac_w;
        return {8'd1, v[23:0]};
    endfunction

    function automatic logic [PER_W-1:0] eff_period(input logic [PER_W-1:0] p);
        return (p == '0) ? PER_W'(1) : p;
    endfunction

    function automatic reg_addr_e lowest_word(input mode_e m);
        return (m == MODE_FIXED_STEP) ? RA_SUB : RA_LO;
    endfunction

endpackage

// File: rtl/ptpc_regs.sv
module ptpc_regs
    import ptpc_pkg::*;
#(
    parameter mode_e MODE   = MODE_FRAC_INC,
    parameter int    FRAC_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_addr_e         addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] step_q,
    output logic              halt,
    output logic              step_wr,
    output load_req_t         ld
);
    localparam logic [WORD_W-1:0] STEP_RST =
        (MODE == MODE_FRAC_INC) ? nominal_step(FRAC_W) : '0;

    logic [WORD_W-1:0] sub_stg;
    logic [WORD_W-1:0] lo_stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= STEP_RST;
            halt    <= 1'b0;
            sub_stg <= '0;
            lo_stg  <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_SUB:  sub_stg <= wdata;
                RA_LO:   lo_stg  <= wdata;
                RA_STEP: step_q  <= wdata;
                RA_CTRL: halt    <= wdata[HALT_BIT];
                default: ;
            endcase
        end
    end

    always_comb begin
        ld.load = wr_en && (addr == RA_HI);
        ld.hi   = wdata;
        ld.lo   = lo_stg;
        ld.sub  = sub_stg;
        step_wr = wr_en && (addr == RA_STEP);
    end

    // R8: staging a lower word leaves the committed load request idle
    p_stage_only_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_LO) |-> !ld.load);

endmodule

// File: rtl/ptpc_core.sv
module ptpc_core
    import ptpc_pkg::*;
#(
    parameter mode_e MODE   = MODE_FRAC_INC,
    parameter int    FRAC_W = 19,
    parameter int    A_TW   = 45,
    parameter int    B_NSW  = 40,
    parameter int    B_STEP = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] step_q,
    input  logic              halt,
    input  logic              step_wr,
    input  load_req_t         ld,
    output time_words_t       live
);
    logic [2*WORD_W-1:0] ld_full;
    assign ld_full = {ld.hi, ld.lo};

    generate
        if (MODE == MODE_FRAC_INC) begin : g_frac
            logic [A_TW-1:0]  acc;
            logic [PER_W-1:0] phase;
            logic             add_now;
            logic [A_TW-1:0]  ld_val;
            logic             unused_a;

            assign unused_a = ^{ld.sub, ld_full[2*WORD_W-1:A_TW]};
            assign ld_val   = ld_full[A_TW-1:0];
            assign add_now  = (phase == eff_period(step_q[31:24]) - PER_W'(1));

            always_ff @(posedge clk) begin
                if (rst) begin
                    acc   <= '0;
                    phase <= '0;
                end else if (ld.load) begin
                    acc   <= ld_val;
                    phase <= '0;
                end else if (step_wr) begin
                    phase <= '0;
                end else if (!halt) begin
                    if (add_now) begin
                        acc   <= acc + A_TW'(step_q[23:0]);
                        phase <= '0;
                    end else begin
                        phase <= phase + PER_W'(1);
                    end
                end
            end

            assign live.sub = '0;
            assign live.lo  = acc[WORD_W-1:0];
            assign live.hi  = WORD_W'(acc[A_TW-1:WORD_W]);

            p_halt_hold_r6: assert property (@(posedge clk) disable iff (rst)
                (halt && !ld.load) |=> $stable(acc));
            p_off_phase_hold_r4: assert property (@(posedge clk) disable iff (rst)
                (!add_now && !ld.load) |=> $stable(acc));
            p_load_commit_r8: assert property (@(posedge clk) disable iff (rst)
                ld.load |=> (acc == $past(ld_val)));
        end else begin : g_fixed
            logic [B_NSW-1:0]  ns;
            logic [WORD_W-1:0] sub;
            logic [WORD_W:0]   fsum;
            logic              carry;
            logic              borrow;
            logic [B_NSW-1:0]  ns_step;
            logic [B_NSW-1:0]  ld_val;
            logic              unused_b;

            assign unused_b = ^{step_wr, ld_full[2*WORD_W-1:B_NSW]};
            assign ld_val   = ld_full[B_NSW-1:0];

            always_comb begin
                if (step_q[SIGN_BIT])
                    fsum = {1'b0, sub} - {2'b0, step_q[30:0]};
                else
                    fsum = {1'b0, sub} + {2'b0, step_q[30:0]};
                carry   = ~step_q[SIGN_BIT] & fsum[WORD_W];
                borrow  =  step_q[SIGN_BIT] & fsum[WORD_W];
                ns_step = B_NSW'(B_STEP) + B_NSW'(carry) - B_NSW'(borrow);
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    ns  <= '0;
                    sub <= '0;
                end else if (ld.load) begin
                    ns  <= ld_val;
                    sub <= ld.sub;
                end else if (!halt) begin
                    ns  <= ns + ns_step;
                    sub <= fsum[WORD_W-1:0];
                end
            end

            assign live.sub = sub;
            assign live.lo  = ns[WORD_W-1:0];
            assign live.hi  = WORD_W'(ns[B_NSW-1:WORD_W]);

            p_step_range_r9: assert property (@(posedge clk) disable iff (rst)
                (!halt && !ld.load) |=>
                    ((ns - $past(ns)) == B_NSW'(B_STEP - 1)) ||
                    ((ns - $past(ns)) == B_NSW'(B_STEP)) ||
                    ((ns - $past(ns)) == B_NSW'(B_STEP + 1)));
            p_halt_hold_r6: assert property (@(posedge clk) disable iff (rst)
                (halt && !ld.load) |=> ($stable(ns) && $stable(sub)));
            p_load_commit_r8: assert property (@(posedge clk) disable iff (rst)
                ld.load |=> (ns == $past(ld_val)));
        end
    endgenerate

endmodule

// File: rtl/ptpc_snap.sv
module ptpc_snap
    import ptpc_pkg::*;
#(
    parameter mode_e MODE  = MODE_FRAC_INC,
    parameter int    HI_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  reg_addr_e         addr,
    input  time_words_t       live,
    input  logic [WORD_W-1:0] step_q,
    input  logic              halt,
    output logic [WORD_W-1:0] rdata
);
    localparam reg_addr_e LOWEST = lowest_word(MODE);

    time_words_t       snap;
    logic              cap;
    logic [WORD_W-1:0] rd_next;

    assign cap = rd_en && (addr == LOWEST);

    always_comb begin
        case (addr)
            RA_SUB:  rd_next = (MODE == MODE_FIXED_STEP) ? live.sub : '0;
            RA_LO:   rd_next = (LOWEST == RA_LO) ? live.lo : snap.lo;
            RA_HI:   rd_next = snap.hi;
            RA_STEP: rd_next = step_q;
            RA_CTRL: rd_next = {halt, {(WORD_W-1){1'b0}}};
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap  <= '0;
            rdata <= '0;
        end else begin
            if (cap)
                snap <= live;
            if (rd_en)
                rdata <= rd_next;
        end
    end

    p_snap_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(snap));

    // R3 and R12: reserved high-word bits stay clear in the captured copy
    always_comb begin
        if (!rst)
            p_hi_reserved_r12: assert (snap.hi[WORD_W-1:HI_W] == '0);
    end

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
    import ptpc_pkg::*;
#(
    parameter mode_e MODE   = MODE_FRAC_INC,
    parameter int    FRAC_W = 19,
    parameter int    A_TW   = 45,
    parameter int    B_NSW  = 40,
    parameter int    B_STEP = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic        reg_rd_en,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    localparam int HI_W = (MODE == MODE_FRAC_INC) ? (A_TW - WORD_W) : (B_NSW - WORD_W);

    reg_addr_e         addr_e;
    logic [WORD_W-1:0] step_q;
    logic              halt;
    logic              step_wr;
    load_req_t         ld;
    time_words_t       live;

    assign addr_e = reg_addr_e'(reg_addr);

    ptpc_regs #(.MODE(MODE), .FRAC_W(FRAC_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(addr_e), .wdata(reg_wdata),
        .step_q(step_q), .halt(halt), .step_wr(step_wr), .ld(ld)
    );

    ptpc_core #(.MODE(MODE), .FRAC_W(FRAC_W), .A_TW(A_TW), .B_NSW(B_NSW), .B_STEP(B_STEP)) u_core (
        .clk(clk), .rst(rst), .step_q(step_q), .halt(halt), .step_wr(step_wr),
        .ld(ld), .live(live)
    );

    ptpc_snap #(.MODE(MODE), .HI_W(HI_W)) u_snap (
        .clk(clk), .rst(rst), .rd_en(reg_rd_en), .addr(addr_e), .live(live),
        .step_q(step_q), .halt(halt), .rdata(reg_rdata)
    );

endmodule

// File: tb/test_ptp_time_counter.sv
module test_ptp_time_counter;
    import ptpc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
    logic [2:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wd = 0, b_wd = 0, a_rdata, b_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    ptp_time_counter #(.MODE(MODE_FRAC_INC)) i_ptp_time_counter (
        .clk(clk), .rst(rst), .reg_wr_en(a_wr), .reg_rd_en(a_rd), .reg_addr(a_addr),
        .reg_wdata(a_wd), .reg_rdata(a_rdata));

    ptp_time_counter #(.MODE(MODE_FIXED_STEP)) i_ptp_time_counter_b (
        .clk(clk), .rst(rst), .reg_wr_en(b_wr), .reg_rd_en(b_rd), .reg_addr(b_addr),
        .reg_wdata(b_wd), .reg_rdata(b_rdata));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input bit b, input logic [2:0] a, input logic [31:0] d);
        if (b) begin b_wr = 1; b_addr = a; b_wd = d; end
        else   begin a_wr = 1; a_addr = a; a_wd = d; end
        @(negedge clk);
        a_wr = 0; b_wr = 0;
    endtask

    task automatic rd(input bit b, input logic [2:0] a, output logic [31:0] d);
        if (b) begin b_rd = 1; b_addr = a; end
        else   begin a_rd = 1; a_addr = a; end
        @(negedge clk);
        d = b ? b_rdata : a_rdata;
        a_rd = 0; b_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_time_a(input logic [31:0] hi, input logic [31:0] lo);
        wr(0, 3'd1, lo);
        wr(0, 3'd2, hi);
    endtask

    task automatic set_time_b(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] sub);
        wr(1, 3'd0, sub);
        wr(1, 3'd1, lo);
        wr(1, 3'd2, hi);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(0, 3'd1, d); chk("R1 time after reset", d, 32'h0);
        rd(0, 3'd3, d); chk("R1 step reset A", d, 32'h0180_0000);
        rd(0, 3'd4, d); chk("R1 ctrl reset", d, 32'h0);
        rd(1, 3'd3, d); chk("R1 step reset B", d, 32'h0);
    endtask

    task automatic t_nominal;
        logic [31:0] d;
        set_time_a(32'h2, 32'h1000);
        rd(0, 3'd1, d); chk("R2 lo with no ticks", d, 32'h1000);
        set_time_a(32'h2, 32'h1000);
        idle(10);
        rd(0, 3'd1, d); chk("R2 lo after 10 ticks", d, 32'h0500_1000);
        rd(0, 3'd2, d); chk("R2 hi after 10 ticks", d, 32'h2);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        set_time_a(32'h1FFF, 32'hFF80_0000);
        idle(1);
        rd(0, 3'd1, d); chk("R3 wrap lo", d, 32'h0);
        rd(0, 3'd2, d); chk("R3 wrap hi", d, 32'h0);
    endtask

    task automatic t_period;
        logic [31:0] d;
        wr(0, 3'd3, 32'h0380_0000);
        rd(0, 3'd3, d); chk("R4 step readback", d, 32'h0380_0000);
        set_time_a(32'h0, 32'h0);
        idle(7);
        rd(0, 3'd1, d); chk("R4 period 3 over 7 ticks", d, 32'h0100_0000);
        wr(0, 3'd3, 32'h0080_0000);
        set_time_a(32'h0, 32'h0);
        idle(3);
        rd(0, 3'd1, d); chk("R4 period 0 acts as 1", d, 32'h0180_0000);
    endtask

    task automatic t_trim;
        logic [31:0] d;
        wr(0, 3'd3, 32'h0180_0001);
        set_time_a(32'h0, 32'h0);
        idle(4);
        rd(0, 3'd1, d); chk("R5 trimmed step x4", d, 32'h0200_0004);
        wr(0, 3'd3, 32'h0180_0000);
    endtask

    task automatic t_halt;
        logic [31:0] d;
        wr(0, 3'd4, 32'h8000_0000);
        rd(0, 3'd4, d); chk("R6 ctrl readback", d, 32'h8000_0000);
        set_time_a(32'hFFFF_FFFF, 32'h0000_4000);
        idle(10);
        rd(0, 3'd1, d); chk("R6 halted lo", d, 32'h0000_4000);
        rd(0, 3'd2, d); chk("R3 hi upper bits zero", d, 32'h1FFF);
        set_time_a(32'h0, 32'h100);
        wr(0, 3'd4, 32'h0);
        idle(2);
        rd(0, 3'd1, d); chk("R6 resume two ticks", d, 32'h0100_0100);
    endtask

    task automatic t_snapshot;
        logic [31:0] d;
        set_time_a(32'h5, 32'hFF80_0000);
        rd(0, 3'd1, d); chk("R7 lowest read live", d, 32'hFF80_0000);
        idle(3);
        rd(0, 3'd2, d); chk("R7 hi from snapshot", d, 32'h5);
    endtask

    task automatic t_staging;
        logic [31:0] d;
        wr(0, 3'd4, 32'h8000_0000);
        set_time_a(32'h1, 32'h1234);
        wr(0, 3'd1, 32'h9999);
        rd(0, 3'd1, d); chk("R8 staged lo not applied", d, 32'h1234);
        wr(0, 3'd2, 32'h3);
        rd(0, 3'd1, d); chk("R8 commit lo", d, 32'h9999);
        rd(0, 3'd2, d); chk("R8 commit hi", d, 32'h3);
        wr(0, 3'd4, 32'h0);
    endtask

    task automatic t_fixed;
        logic [31:0] d;
        set_time_b(32'h0, 32'h100, 32'h0);
        idle(5);
        rd(1, 3'd0, d); chk("R9 sub stays zero", d, 32'h0);
        rd(1, 3'd1, d); chk("R9 8 ns per tick", d, 32'h128);
        set_time_b(32'h0, 32'hFFFF_FFF8, 32'h0);
        idle(1);
        rd(1, 3'd0, d);
        rd(1, 3'd1, d); chk("R9 carry lo", d, 32'h0);
        rd(1, 3'd2, d); chk("R9 carry hi", d, 32'h1);
    endtask

    task automatic t_pos;
        logic [31:0] d;
        wr(1, 3'd3, 32'h4000_0000);
        set_time_b(32'h0, 32'h0, 32'h0);
        idle(5);
        rd(1, 3'd0, d); chk("R10 sub after 5", d, 32'h4000_0000);
        rd(1, 3'd1, d); chk("R10 ns after 5", d, 32'd41);
    endtask

    task automatic t_neg;
        logic [31:0] d;
        wr(1, 3'd3, 32'hC000_0000);
        set_time_b(32'h0, 32'h1000, 32'h0);
        idle(5);
        rd(1, 3'd0, d); chk("R11 sub after 5", d, 32'hC000_0000);
        rd(1, 3'd1, d); chk("R11 ns after 5", d, 32'h1000 + 32'd38);
        wr(1, 3'd3, 32'h0);
    endtask

    task automatic t_reserved_b;
        logic [31:0] d;
        wr(1, 3'd4, 32'h8000_0000);
        set_time_b(32'hFFFF_FFFF, 32'h0, 32'h0);
        rd(1, 3'd0, d);
        rd(1, 3'd2, d); chk("R12 hi reserved zero", d, 32'h0000_00FF);
        wr(1, 3'd4, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset();
        t_nominal();
        t_wrap();
        t_period();
        t_trim();
        t_halt();
        t_snapshot();
        t_staging();
        t_fixed();
        t_pos();
        t_neg();
        t_reserved_b();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule